// File: doc/BRIEF.md
# Serial Flash Master with Command-Launched Transfer Engine

This block is a serial-peripheral-interface master for byte-oriented flash devices, controlled through a small 32-bit register window. Software describes a whole transaction up front: a mode code that fixes which byte phases occur and in what order, a write byte count and a read byte count, each stored as the count minus one. One write to the launch register then runs the transaction with no further register traffic, apart from feeding and draining the FIFOs.

Outgoing bytes are taken from a 16-entry transmit FIFO, and incoming bytes are placed in a 16-entry receive FIFO. Both FIFOs sit behind a single data port. The serial side drives a clock, a data-out line and one active-low select, and it samples a data-in line. When the transmit FIFO runs dry or the receive FIFO fills, the serial clock stops between bytes and the select stays low. The transfer resumes as soon as the FIFO condition clears. A control register gives self-clearing resets for the whole engine and for each FIFO.

Top module: `spi_flash_master`

## Requirements
- R1: After reset, status (offset 0x34) reads 0x00404000, the format register (0x10) reads 0x00000700 (8-bit frames, length minus one at bit 8), timing (0x40) reads 0, chip select is high, and the serial clock and data-out are low.
- R2: The transfer control register (0x20) keeps only bits 27:24 (mode), 20:12 (write count minus one) and 8:0 (read count minus one), so writing all ones reads back 0x0F1FF1FF. A write of any value to 0x24 while idle starts the programmed transaction.
- R3: Mode codes set the byte phases: 0 sends and receives on the same bytes (length from the write count); 1 only sends; 2 only receives; 3 sends, then receives; 4 receives, then sends. Received bytes enter the receive FIFO in wire order.
- R4: Bytes go out MSB first in clock mode 0: data-out changes while the clock is low, and data-in is sampled on the rising edge. Data-out is low during receive-only bytes. Chip select is low for the whole transaction and high otherwise. The clock is low whenever chip select is high.
- R5: With value d in timing bits 7:0, each clock half period lasts d+1 system clocks, so the clock runs at the system clock divided by 2*(d+1).
- R6: A write to the data port (0x2C) pushes bits 7:0 into the transmit FIFO and is dropped when that FIFO holds 16 bytes. A read pops the receive FIFO and returns 0 when it is empty.
- R7: The status fields are: bit 0 busy, bits 12:8 receive count, bit 14 receive empty, bits 20:16 transmit count, bit 22 transmit empty, bit 23 transmit full.
- R8: When a sending byte finds the transmit FIFO empty, the engine waits with the clock low, chip select low and busy set. It continues once a byte is written.
- R9: When a receiving byte finds the receive FIFO full, the engine waits in the same way until a byte is popped.
- R10: Writing 1 to control bit 0 (offset 0x30) aborts any transaction and empties both FIFOs one cycle later. The control bits then read back as 0.
- R11: Control bit 1 empties only the receive FIFO, and control bit 2 empties only the transmit FIFO.
- R12: Mode 7, and any code other than 0 to 4, sets busy without producing any clock edge or select pulse.
- R13: A write to 0x24 while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the data port) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |

## Verification
Two things can land on the same clock edge. A register-side pop of the receive FIFO can coincide with the engine pushing a just-completed byte, and a register-side push into the transmit FIFO can coincide with the engine taking its next byte. The bench provokes both with a long full-duplex transfer at the fastest divider. It feeds and drains the FIFOs as fast as the status register allows, so each FIFO sees a simultaneous push and pop at some edge. The result is judged by every received byte arriving in wire order with none lost or duplicated, by every sent byte appearing on data-out, and by both counts ending at zero.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam logic [7:0] A_FMT  = 8'h10;
    localparam logic [7:0] A_XCTL = 8'h20;
    localparam logic [7:0] A_GO   = 8'h24;
    localparam logic [7:0] A_DATA = 8'h2C;
    localparam logic [7:0] A_CTL  = 8'h30;
    localparam logic [7:0] A_STAT = 8'h34;
    localparam logic [7:0] A_TIME = 8'h40;

    typedef enum logic [1:0] {PK_NONE, PK_W, PK_R, PK_WR} pkind_e;
    typedef enum logic [2:0] {ES_IDLE, ES_LOAD, ES_LOW, ES_HIGH, ES_FIN} est_e;

    // phase kind for a mode code and phase index (0 = first, 1 = second)
    function automatic pkind_e phase_kind(input logic [3:0] mode, input logic idx);
        pkind_e k;
        k = PK_NONE;
        case (mode)
            4'd0: if (!idx) k = PK_WR;
            4'd1: if (!idx) k = PK_W;
            4'd2: if (!idx) k = PK_R;
            4'd3: if (!idx) k = PK_W; else k = PK_R;
            4'd4: if (!idx) k = PK_R; else k = PK_W;
            default: k = PK_NONE;
        endcase
        return k;
    endfunction

    function automatic logic kind_tx(input pkind_e k);
        return (k == PK_W) || (k == PK_WR);
    endfunction

    function automatic logic kind_rx(input pkind_e k);
        return (k == PK_R) || (k == PK_WR);
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fptr_t;

    fptr_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[q.rp];
    assign count   = q.cnt;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (do_push) d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
            if (do_pop)  d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[q.wp] <= wdata;
    end

endmodule

// File: rtl/spim_engine.sv
module spim_engine import spim_pkg::*; #(
    parameter int FW  = 8,
    parameter int CW  = 9,
    parameter int TW  = 8,
    localparam int BW = $clog2(FW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [CW-1:0] wlen,
    input  logic [CW-1:0] rlen,
    input  logic [TW-1:0] div,
    input  logic [FW-1:0] tx_data,
    input  logic          tx_empty,
    output logic          tx_pop,
    input  logic          rx_full,
    output logic          rx_push,
    output logic [FW-1:0] rx_data,
    input  logic          miso,
    output logic          busy,
    output logic          sclk,
    output logic          mosi,
    output logic          cs_n
);
    typedef struct packed {
        est_e          st;
        logic          ph;
        logic [3:0]    mode;
        logic [CW-1:0] wlen;
        logic [CW-1:0] rlen;
        logic [TW-1:0] div;
        logic [TW-1:0] cnt;
        logic [BW-1:0] bitn;
        logic [CW-1:0] bytec;
        logic [FW-1:0] txsh;
        logic [FW-1:0] rxsh;
    } eng_t;

    eng_t q, d;
    pkind_e kind;
    logic [CW-1:0] plen;
    logic active;

    assign kind    = phase_kind(q.mode, q.ph);
    assign plen    = (kind == PK_R) ? q.rlen : q.wlen;
    assign active  = (q.st == ES_LOAD) || (q.st == ES_LOW) || (q.st == ES_HIGH);
    assign busy    = (q.st != ES_IDLE);
    assign cs_n    = !active;
    assign sclk    = (q.st == ES_HIGH);
    assign mosi    = ((q.st == ES_LOW) || (q.st == ES_HIGH)) && q.txsh[FW-1];
    assign rx_data = q.rxsh;

    always_comb begin
        d       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        case (q.st)
            ES_IDLE: if (start) begin
                d.mode  = mode;
                d.wlen  = wlen;
                d.rlen  = rlen;
                d.div   = div;
                d.ph    = 1'b0;
                d.bytec = '0;
                d.st    = (phase_kind(mode, 1'b0) == PK_NONE) ? ES_FIN : ES_LOAD;
            end
            ES_LOAD: if ((!kind_tx(kind) || !tx_empty) && (!kind_rx(kind) || !rx_full)) begin
                tx_pop = kind_tx(kind);
                d.txsh = kind_tx(kind) ? tx_data : '0;
                d.cnt  = '0;
                d.bitn = '0;
                d.st   = ES_LOW;
            end
            ES_LOW: if (q.cnt == q.div) begin
                d.cnt  = '0;
                d.rxsh = {q.rxsh[FW-2:0], miso};
                d.st   = ES_HIGH;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
            ES_HIGH: if (q.cnt == q.div) begin
                d.cnt = '0;
                if (q.bitn == BW'(FW - 1)) begin
                    rx_push = kind_rx(kind);
                    if (q.bytec == plen) begin
                        d.bytec = '0;
                        if (!q.ph && (phase_kind(q.mode, 1'b1) != PK_NONE)) begin
                            d.ph = 1'b1;
                            d.st = ES_LOAD;
                        end else begin
                            d.st = ES_FIN;
                        end
                    end else begin
                        d.bytec = q.bytec + 1'b1;
                        d.st    = ES_LOAD;
                    end
                end else begin
                    d.bitn = q.bitn + 1'b1;
                    d.txsh = {q.txsh[FW-2:0], 1'b0};
                    d.st   = ES_LOW;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
            ES_FIN:  d.st = ES_IDLE;
            default: d.st = ES_IDLE;
        endcase
        if (abort) d.st = ES_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/spi_flash_master.sv
module spi_flash_master import spim_pkg::*; #(
    parameter int FIFO_DEPTH = 16,
    parameter int FW         = 8,
    parameter int CW         = 9,
    parameter int TW         = 8,
    localparam int FCW       = $clog2(FIFO_DEPTH + 1),
    localparam int W_LSB     = 12,
    localparam int R_LSB     = 0,
    localparam int M_LSB     = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        miso,
    output logic        sclk,
    output logic        mosi,
    output logic        cs_n
);
    localparam logic [31:0] XCTL_MASK =
        (32'hF << M_LSB) | (((32'h1 << CW) - 1) << W_LSB) | (((32'h1 << CW) - 1) << R_LSB);

    typedef struct packed {
        logic [31:0]   xctl;
        logic [TW-1:0] tdiv;
        logic [2:0]    rpend;
    } regs_t;

    regs_t q, d;

    logic           eng_busy, eng_start, eng_abort;
    logic           tx_push, tx_pop, tx_full, tx_empty, tx_clr;
    logic           rx_push, rx_pop, rx_full, rx_empty, rx_clr;
    logic [FW-1:0]  tx_q, rx_q, rx_in;
    logic [FCW-1:0] tx_cnt, rx_cnt;
    logic [31:0]    stat;

    assign eng_abort = q.rpend[0];
    assign tx_clr    = q.rpend[0] | q.rpend[2];
    assign rx_clr    = q.rpend[0] | q.rpend[1];
    assign eng_start = bus_wr && (bus_addr == A_GO) && !eng_busy && (q.rpend == '0);
    assign tx_push   = bus_wr && (bus_addr == A_DATA);
    assign rx_pop    = bus_rd && (bus_addr == A_DATA);

    always_comb begin
        d = q;
        if (q.rpend != '0) d.rpend = '0;
        if (bus_wr) begin
            case (bus_addr)
                A_XCTL:  d.xctl  = bus_wdata & XCTL_MASK;
                A_TIME:  d.tdiv  = bus_wdata[TW-1:0];
                A_CTL:   d.rpend = bus_wdata[2:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        stat        = '0;
        stat[0]     = eng_busy;
        stat[12:8]  = 5'(rx_cnt);
        stat[14]    = rx_empty;
        stat[20:16] = 5'(tx_cnt);
        stat[22]    = tx_empty;
        stat[23]    = tx_full;
        case (bus_addr)
            A_FMT:   bus_rdata = 32'(FW - 1) << 8;
            A_XCTL:  bus_rdata = q.xctl;
            A_DATA:  bus_rdata = rx_empty ? '0 : {{(32-FW){1'b0}}, rx_q};
            A_CTL:   bus_rdata = {29'b0, q.rpend};
            A_STAT:  bus_rdata = stat;
            A_TIME:  bus_rdata = {{(32-TW){1'b0}}, q.tdiv};
            default: bus_rdata = '0;
        endcase
    end

    spim_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .pop(tx_pop),
        .wdata(bus_wdata[FW-1:0]), .rdata(tx_q), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .pop(rx_pop),
        .wdata(rx_in), .rdata(rx_q), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty)
    );

    spim_engine #(.FW(FW), .CW(CW), .TW(TW)) u_eng (
        .clk(clk), .rst_n(rst_n), .abort(eng_abort), .start(eng_start),
        .mode(q.xctl[M_LSB +: 4]), .wlen(q.xctl[W_LSB +: CW]), .rlen(q.xctl[R_LSB +: CW]),
        .div(q.tdiv), .tx_data(tx_q), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_in), .miso(miso),
        .busy(eng_busy), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
    parameter int CNTW  = 5,
    parameter int DEPTH = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            start,
    input logic            abort,
    input logic            cs_n,
    input logic            sclk,
    input logic [CNTW-1:0] tx_cnt,
    input logic [CNTW-1:0] rx_cnt
);
    // R4
    idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
    // R4
    sel_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy);
    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy);
    // R10
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && cs_n && tx_cnt == '0 && rx_cnt == '0));
    // R6
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CNTW'(DEPTH)) && (rx_cnt <= CNTW'(DEPTH)));
endmodule

bind spi_flash_master spim_chk #(.CNTW(FCW), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(eng_busy), .start(eng_start), .abort(eng_abort),
    .cs_n(cs_n), .sclk(sclk), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/sim_spi_flash_master.sv
`timescale 1ns/1ps
module sim_spi_flash_master;
    localparam logic [7:0] A_FMT = 8'h10, A_XCTL = 8'h20, A_GO = 8'h24, A_DATA = 8'h2C;
    localparam logic [7:0] A_CTL = 8'h30, A_STAT = 8'h34, A_TIME = 8'h40;

    logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic miso, sclk, mosi, cs_n;

    spi_flash_master u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n));

    always #4 clk = ~clk;

    int nchk = 0, nerr = 0;
    logic [7:0] stx [0:127];
    logic [7:0] mo  [0:127];
    logic [7:0] wb  [0:63];
    int mo_n = 0, cs_falls = 0, rise_idx = 0;
    logic [2:0] bc = 0;
    logic [7:0] cur = 0;
    realtime t_r0 = 0, t_r1 = 0, t_hi = 0;

    assign miso = stx[mo_n & 127][3'd7 - bc];

    always @(posedge sclk) begin
        cur = {cur[6:0], mosi};
        if (bc == 3'd7) begin mo[mo_n & 127] = cur; mo_n++; bc = 0; end
        else bc = bc + 3'd1;
        if (rise_idx == 0) t_r0 = $realtime;
        else if (rise_idx == 1) t_r1 = $realtime;
        rise_idx++;
    end
    always @(negedge sclk) if (rise_idx == 1) t_hi = $realtime - t_r0;
    always @(negedge cs_n) cs_falls++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); bus_rd = 1; bus_addr = a; #1 v = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int g = 0;
        do begin rd(A_STAT, v); g++; end while (v[0] && g < 20000);
        chk(!v[0], req, v, 32'h0);
    endtask

    function automatic logic [31:0] xw(input int m, input int wn, input int rn);
        return {4'h0, 4'(m), 3'b0, 9'(wn - 1), 3'b0, 9'(rn - 1)};
    endfunction
    function automatic int tx_n(input int m, input int wn);
        return (m == 0 || m == 1 || m == 3 || m == 4) ? wn : 0;
    endfunction
    function automatic int rx_n(input int m, input int wn, input int rn);
        return (m == 0) ? wn : ((m == 2 || m == 3 || m == 4) ? rn : 0);
    endfunction
    function automatic int wire_n(input int m, input int wn, input int rn);
        return (m == 0) ? wn : tx_n(m, wn) + rx_n(m, wn, rn);
    endfunction
    function automatic logic [7:0] exp_mosi(input int m, input int wn, input int rn, input int i);
        case (m)
            0, 1:    return wb[i];
            3:       return (i < wn) ? wb[i] : 8'h00;
            4:       return (i < rn) ? 8'h00 : wb[i - rn];
            default: return 8'h00;
        endcase
    endfunction
    function automatic logic [7:0] exp_rx(input int m, input int wn, input int j);
        return (m == 3) ? stx[wn + j] : stx[j];
    endfunction

    task automatic fill_stx();
        for (int i = 0; i < 128; i++) stx[i] = 8'($urandom);
    endtask

    // full transaction with expected values from the mode rules (R2, R3, R4)
    task automatic run_xact(input int m, input int wn, input int rn, input int dv);
        logic [31:0] v;
        int bad = 0, cf0, nt, nr, nw;
        nt = tx_n(m, wn); nr = rx_n(m, wn, rn); nw = wire_n(m, wn, rn);
        fill_stx();
        mo_n = 0; bc = 0; cf0 = cs_falls;
        wr(A_TIME, 32'(dv));
        for (int i = 0; i < nt; i++) begin wb[i] = 8'($urandom); wr(A_DATA, {24'h0, wb[i]}); end
        wr(A_XCTL, xw(m, wn, rn));
        wr(A_GO, 32'h0);
        wait_idle("R2 busy clears");
        chk(mo_n == nw, "R3 wire byte count", 32'(mo_n), 32'(nw));
        for (int i = 0; i < nw; i++) if (mo[i] !== exp_mosi(m, wn, rn, i)) bad++;
        chk(bad == 0, "R4 mosi bytes", 32'(bad), 0);
        chk(cs_falls - cf0 == ((nw > 0) ? 1 : 0), "R4 select pulses", 32'(cs_falls - cf0), 32'((nw > 0) ? 1 : 0));
        rd(A_STAT, v);
        chk(v[12:8] == 5'(nr), "R7 rx count", {27'h0, v[12:8]}, 32'(nr));
        bad = 0;
        for (int j = 0; j < nr; j++) begin rd(A_DATA, v); if (v[7:0] !== exp_rx(m, wn, j)) bad++; end
        chk(bad == 0, "R3 rx bytes", 32'(bad), 0);
        chk(cs_n === 1'b1 && sclk === 1'b0, "R4 idle lines", {30'h0, cs_n, sclk}, 32'h2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int bad, fed, got, g, cf0;
        void'($urandom(32'h5A17C3));
        fill_stx();
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 / R7 reset state
        rd(A_STAT, v); chk(v == 32'h00404000, "R1 status reset", v, 32'h00404000);
        rd(A_FMT, v);  chk(v == 32'h00000700, "R1 format", v, 32'h700);
        rd(A_TIME, v); chk(v == 32'h0, "R1 timing", v, 0);
        chk(cs_n === 1 && sclk === 0 && mosi === 0, "R1 pins", {29'h0, cs_n, sclk, mosi}, 32'h4);
        // R2 field mask
        wr(A_XCTL, 32'hFFFFFFFF); rd(A_XCTL, v); chk(v == 32'h0F1FF1FF, "R2 readback", v, 32'h0F1FF1FF);
        // R3 each mode directed
        run_xact(0, 3, 3, 0);
        run_xact(1, 5, 1, 1);
        run_xact(2, 1, 4, 0);
        run_xact(3, 4, 3, 2);
        run_xact(4, 2, 5, 0);
        // R12 no-data and unsupported codes
        run_xact(7, 1, 1, 0);
        run_xact(5, 3, 3, 0);
        // R5 divider
        rise_idx = 0;
        run_xact(1, 2, 1, 3);
        chk(t_r1 - t_r0 == 64.0, "R5 period", 32'(int'(t_r1 - t_r0)), 64);
        chk(t_hi == 32.0, "R5 high time", 32'(int'(t_hi)), 32);
        // R8 tx underflow stall
        mo_n = 0; bc = 0; wr(A_TIME, 0);
        for (int i = 0; i < 20; i++) wb[i] = 8'($urandom);
        for (int i = 0; i < 16; i++) wr(A_DATA, {24'h0, wb[i]});
        wr(A_XCTL, xw(1, 20, 1)); wr(A_GO, 0);
        repeat (400) @(negedge clk);
        rd(A_STAT, v);
        chk(v[0] && v[22] && !cs_n && !sclk && mo_n == 16, "R8 stall", {v[0], v[22], cs_n, sclk, 28'(mo_n)}, 32'hC0000010);
        for (int i = 16; i < 20; i++) wr(A_DATA, {24'h0, wb[i]});
        wait_idle("R8 resume");
        bad = 0; for (int i = 0; i < 20; i++) if (mo[i] !== wb[i]) bad++;
        chk(mo_n == 20 && bad == 0, "R8 bytes", 32'(bad), 0);
        // R9 rx full stall
        fill_stx(); mo_n = 0; bc = 0;
        wr(A_XCTL, xw(2, 1, 20)); wr(A_GO, 0);
        repeat (600) @(negedge clk);
        rd(A_STAT, v);
        chk(v[0] && v[12:8] == 5'd16 && !cs_n && mo_n == 16, "R9 stall", {27'h0, v[12:8]}, 16);
        bad = 0; got = 0; g = 0;
        while (got < 20 && g < 5000) begin
            g++; rd(A_STAT, v);
            if (v[12:8] != 0) begin rd(A_DATA, v); if (v[7:0] !== stx[got]) bad++; got++; end
        end
        chk(got == 20 && bad == 0, "R9 bytes", 32'(bad), 0);
        // concurrent feed and drain, full duplex 60 bytes (R6, R3)
        fill_stx(); mo_n = 0; bc = 0;
        for (int i = 0; i < 60; i++) wb[i] = 8'($urandom);
        wr(A_XCTL, xw(0, 60, 60)); wr(A_GO, 0);
        fed = 0; got = 0; bad = 0; g = 0;
        while (got < 60 && g < 20000) begin
            g++; rd(A_STAT, v);
            if (fed < 60 && !v[23]) begin wr(A_DATA, {24'h0, wb[fed]}); fed++; end
            if (v[12:8] != 0) begin rd(A_DATA, v); if (v[7:0] !== stx[got]) bad++; got++; end
        end
        wait_idle("R3 duplex end");
        chk(got == 60 && bad == 0, "R3 duplex rx", 32'(bad), 0);
        bad = 0; for (int i = 0; i < 60; i++) if (mo[i] !== wb[i]) bad++;
        chk(mo_n == 60 && bad == 0, "R6 duplex tx", 32'(bad), 0);
        rd(A_STAT, v); chk(v == 32'h00404000, "R7 duplex final", v, 32'h00404000);
        // R13 relaunch while busy ignored
        mo_n = 0; bc = 0; cf0 = cs_falls; wr(A_TIME, 2);
        for (int i = 0; i < 4; i++) wr(A_DATA, 32'hA0 + 32'(i));
        wr(A_XCTL, xw(1, 4, 1)); wr(A_GO, 0); wr(A_GO, 0);
        wait_idle("R13 idle");
        repeat (20) @(negedge clk);
        chk(mo_n == 4 && cs_falls - cf0 == 1, "R13 single run", 32'(mo_n), 4);
        // R10 abort
        wr(A_TIME, 3);
        for (int i = 0; i < 10; i++) wr(A_DATA, 32'h55);
        wr(A_XCTL, xw(1, 10, 1)); wr(A_GO, 0);
        repeat (30) @(negedge clk);
        wr(A_CTL, 32'h1);
        rd(A_STAT, v); chk(v == 32'h00404000 && cs_n, "R10 abort", v, 32'h00404000);
        rd(A_CTL, v);  chk(v == 0, "R10 self clear", v, 0);
        // R11 FIFO resets
        run_xact(0, 1, 1, 0);
        wr(A_XCTL, xw(2, 1, 3)); wr(A_GO, 0); wait_idle("R11 prep");
        for (int i = 0; i < 3; i++) wr(A_DATA, 32'h11);
        wr(A_CTL, 32'h4); rd(A_STAT, v);
        chk(v[20:16] == 0 && v[12:8] == 3, "R11 tx reset", {v[20:16], 3'b0, v[12:8]}, 32'h3);
        wr(A_CTL, 32'h2); rd(A_STAT, v);
        chk(v == 32'h00404000, "R11 rx reset", v, 32'h00404000);
        // R6 overflow dropped, empty pop returns 0
        mo_n = 0; bc = 0;
        for (int i = 0; i < 17; i++) begin wb[i] = 8'($urandom); wr(A_DATA, {24'h0, wb[i]}); end
        rd(A_STAT, v); chk(v[23] && v[20:16] == 5'd16, "R6 full", {27'h0, v[20:16]}, 16);
        wr(A_XCTL, xw(1, 16, 1)); wr(A_GO, 0); wait_idle("R6 run");
        bad = 0; for (int i = 0; i < 16; i++) if (mo[i] !== wb[i]) bad++;
        rd(A_STAT, v);
        chk(bad == 0 && v[22], "R6 dropped push", 32'(bad), 0);
        rd(A_DATA, v); chk(v == 0, "R6 empty pop", v, 0);
        // random transactions
        for (int k = 0; k < 12; k++) begin
            int modes [6] = '{0, 1, 2, 3, 4, 7};
            run_xact(modes[$urandom_range(0, 5)], $urandom_range(1, 16), $urandom_range(1, 16), $urandom_range(0, 3));
        end
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule